// File: doc/BRIEF.md
# Dual-Bank Clock Divider with Coincidence Strobe

This block divides one fast source clock into two output clock banks whose frequencies stand in a selectable ratio. The ratio can be an integer (2:1, 3:1) or a fraction (3:2, 5:2). A feedback clock runs at the common repeat rate of the two banks. A one-cycle strobe marks every source cycle in which both banks rise together. The source clock may be a VCO-rate clock or, when the loop is bypassed, the reference clock itself. The division is purely synchronous, so it works at any source rate.

Bank A drives four identical copies and bank B drives three. The ratio code and the bypass flag are captured only while reset is held. A change made during operation therefore cannot cut a period short. On the first source edge after reset is released, both banks, the feedback clock and the strobe all rise together.

Top module: `dualbank_clkdiv`

## Requirements
- R1: The ratio code `ratio_code` sets the bank periods in source cycles (fast, slow): code 0 gives 2,4; code 1 gives 2,6; code 2 gives 2,3; code 3 gives 2,5. In codes 0–3 bank A takes the fast period and bank B the slow one. Codes 4–7 repeat codes 0–3 with the roles of the two banks swapped.
- R2: A bank with period N is high for floor(N/2) source cycles and low for the rest of each period, and each period begins with a rising edge.
- R3: All bits of `bank_a` carry the same value in every cycle, and so do all bits of `bank_b`.
- R4: `coin_strobe` is high for exactly the source cycles in which both banks rise together, and is low otherwise.
- R5: While `rst` is high, every bank output, `fb_clk` and `coin_strobe` are low.
- R6: On the first source edge after `rst` falls, both banks, `fb_clk` and `coin_strobe` all go high.
- R7: `ratio_code` and `pll_bypass` are captured only at source edges while `rst` is high. Changes made while running have no effect until the next reset.
- R8: With the captured bypass flag at 0, `fb_clk` has a period equal to the least common multiple of the two bank periods (4, 6, 6 and 10 for codes 0–3 and their mirrors) and follows the R2 duty rule. With the captured bypass flag at 1, `fb_clk` stays low.
- R9: The bank outputs and `coin_strobe` are the same whatever the captured bypass flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Fast source clock (VCO or reference) |
| rst | input | 1 | Active-high reset, asynchronous assert |
| ratio_code | input | 3 | Bank ratio selection, captured during reset |
| pll_bypass | input | 1 | Bypass flag, captured during reset |
| bank_a | output | 4 | Bank-A clock copies |
| bank_b | output | 3 | Bank-B clock copies |
| fb_clk | output | 1 | Feedback-divider clock |
| coin_strobe | output | 1 | High in cycles where both banks rise together |

## Verification
The assertions assume that reset is held for at least one source edge, so that the ratio code and bypass flag are captured before the first post-reset edge. They also assume that reset is released between edges. The stimulus changes `ratio_code`, `pll_bypass` and `rst` only at falling edges of the source clock, and it holds reset across several rising edges each time. Codes and bypass values are also changed in mid-run, on purpose, to exercise the capture rule without breaking these assumptions.

// File: rtl/dualbank_clkdiv.sv
module dualbank_clkdiv #(
  parameter int A_COPIES = 4,
  parameter int B_COPIES = 3,
  parameter int CW       = 4
) (
  input  logic                clk_src,
  input  logic                rst,
  input  logic [2:0]          ratio_code,
  input  logic                pll_bypass,
  output logic [A_COPIES-1:0] bank_a,
  output logic [B_COPIES-1:0] bank_b,
  output logic                fb_clk,
  output logic                coin_strobe
);

  logic [2:0]    code_q;
  logic          byp_q;
  logic [CW-1:0] fast_n, slow_n, frame_n, na, nb;
  logic [CW-1:0] pa, pb, pf;
  logic          qa, qb, qf, strobe;

  always_ff @(posedge clk_src)
    if (rst) begin
      code_q <= ratio_code;
      byp_q  <= pll_bypass;
    end

  always_comb begin
    fast_n = CW'(2);
    case (code_q[1:0])
      2'd0:    begin slow_n = CW'(4); frame_n = CW'(4);  end
      2'd1:    begin slow_n = CW'(6); frame_n = CW'(6);  end
      2'd2:    begin slow_n = CW'(3); frame_n = CW'(6);  end
      default: begin slow_n = CW'(5); frame_n = CW'(10); end
    endcase
  end

  assign na = code_q[2] ? slow_n : fast_n;
  assign nb = code_q[2] ? fast_n : slow_n;

  always_ff @(posedge clk_src or posedge rst)
    if (rst) begin
      pa <= '0; pb <= '0; pf <= '0;
      qa <= 1'b0; qb <= 1'b0; qf <= 1'b0; strobe <= 1'b0;
    end else begin
      pa     <= (pa == na - 1'b1) ? '0 : pa + 1'b1;
      pb     <= (pb == nb - 1'b1) ? '0 : pb + 1'b1;
      pf     <= (pf == frame_n - 1'b1) ? '0 : pf + 1'b1;
      qa     <= pa < (na >> 1);
      qb     <= pb < (nb >> 1);
      qf     <= !byp_q && (pf < (frame_n >> 1));
      strobe <= (pa == '0) && (pb == '0);
    end

  assign bank_a      = {A_COPIES{qa}};
  assign bank_b      = {B_COPIES{qb}};
  assign fb_clk      = qf;
  assign coin_strobe = strobe;

  always @(posedge clk_src)
    if (rst) a_r5_reset_low: assert (bank_a == '0 && bank_b == '0 && !fb_clk && !coin_strobe);

  a_r4_strobe_on_rise: assert property (@(posedge clk_src) disable iff (rst)
    coin_strobe |-> (bank_a[0] && bank_b[0] && !$past(bank_a[0]) && !$past(bank_b[0])));

  a_r4_rise_gives_strobe: assert property (@(posedge clk_src) disable iff (rst)
    ($rose(bank_a[0]) && $rose(bank_b[0])) |-> coin_strobe);

  a_r4_strobe_single: assert property (@(posedge clk_src) disable iff (rst)
    coin_strobe |=> !coin_strobe);

  a_r8_fb_on_frame: assert property (@(posedge clk_src) disable iff (rst)
    $rose(fb_clk) |-> coin_strobe);

  a_r8_fb_bypass_low: assert property (@(posedge clk_src) disable iff (rst)
    byp_q |-> !fb_clk);

  a_r7_code_held: assert property (@(posedge clk_src) disable iff (rst)
    $stable(code_q) && $stable(byp_q));

endmodule

// File: tb/dualbank_clkdiv_bench.sv
module dualbank_clkdiv_bench;
  logic       clk_src = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] ratio_code = 3'd0;
  logic       pll_bypass = 1'b0;
  logic [3:0] bank_a;
  logic [2:0] bank_b;
  logic       fb_clk, coin_strobe;

  int checks = 0, fails = 0;
  bit done = 0;

  dualbank_clkdiv u_dualbank_clkdiv (
    .clk_src(clk_src), .rst(rst), .ratio_code(ratio_code), .pll_bypass(pll_bypass),
    .bank_a(bank_a), .bank_b(bank_b), .fb_clk(fb_clk), .coin_strobe(coin_strobe));

  always #5 clk_src = ~clk_src;

  function automatic int slow_of(int c);
    case (c % 4)
      0: return 4;
      1: return 6;
      2: return 3;
      default: return 5;
    endcase
  endfunction

  function automatic int lcm(int x, int y);
    int m = x;
    while (m % y != 0) m += x;
    return m;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(int code, bit byp);
    @(negedge clk_src);
    rst = 1'b1;
    ratio_code = 3'(code);
    pll_bypass = byp;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_src);
      chk("R5 reset outputs", {bank_a, bank_b, fb_clk, coin_strobe}, 0);
    end
    rst = 1'b0;
  endtask

  // compares every cycle against a behavioural model; k counts cycles since release
  task automatic run(int code, bit byp, int cycles, int chg_at, int new_code, bit new_byp);
    int na, nb, nf, ea, eb, ef, es, pea, peb;
    na = (code >= 4) ? slow_of(code) : 2;
    nb = (code >= 4) ? 2 : slow_of(code);
    nf = lcm(na, nb);
    pea = 0; peb = 0;
    for (int k = 0; k < cycles; k++) begin
      @(posedge clk_src);
      @(negedge clk_src);
      ea = ((k % na) < na / 2) ? 1 : 0;
      eb = ((k % nb) < nb / 2) ? 1 : 0;
      ef = (!byp && ((k % nf) < nf / 2)) ? 1 : 0;
      es = (ea == 1 && eb == 1 && pea == 0 && peb == 0) ? 1 : 0;
      if (k == 0) begin
        chk("R6 first edge all high", {bank_a[0], bank_b[0], coin_strobe}, 3'b111);
        chk("R6 first edge fb", fb_clk, byp ? 0 : 1);
      end
      chk("R1 R2 R9 bank_a", bank_a, ea ? 4'hF : 4'h0);
      chk("R1 R2 R9 bank_b", bank_b, eb ? 3'h7 : 3'h0);
      chk("R3 bank_a copies", (bank_a == 4'h0 || bank_a == 4'hF) ? 1 : 0, 1);
      chk("R3 bank_b copies", (bank_b == 3'h0 || bank_b == 3'h7) ? 1 : 0, 1);
      chk("R8 fb_clk", fb_clk, ef);
      chk("R4 R9 coin_strobe", coin_strobe, es);
      pea = ea; peb = eb;
      if (k == chg_at) begin
        ratio_code = 3'(new_code);
        pll_bypass = new_byp;
      end
    end
  endtask

  initial begin
    for (int c = 0; c < 8; c++) begin
      do_reset(c, 1'b0);
      run(c, 1'b0, 45, -1, 0, 1'b0);
      do_reset(c, 1'b1);
      run(c, 1'b1, 25, -1, 0, 1'b0);
    end
    // R7: mid-run changes of code and bypass are ignored
    do_reset(3, 1'b0);
    run(3, 1'b0, 60, 13, 6, 1'b1);
    do_reset(6, 1'b1);
    run(6, 1'b1, 40, 7, 1, 1'b0);
    do_reset(1, 1'b0);
    run(1, 1'b0, 30, -1, 0, 1'b0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule